// File: doc/BRIEF.md
# Display window update sequencer

This block sends one rectangular region of pixels to a display controller that keeps its own full frame memory. A flush request carries a rectangle given as first and last column and first and last row, both ends inclusive. The block adds fixed panel offsets to the rectangle and emits a stream of bytes. That stream holds the column-window command and its four parameters, then the row-window command and its four parameters, then the memory-write command, then the pixel data. Every byte carries a flag that says whether it is a command or data. A downstream serial link takes the bytes through a valid/ready handshake.

Pixels come from a source through a second valid/ready handshake. Each pixel is either native 16-bit RGB565 or 32-bit XRGB8888, which the block reduces to RGB565 as it passes. An optional swap mode reverses the two bytes of every pixel. A blank request needs no pixel source: it opens the whole panel as the window and writes zero pixels to all of it.

Top module: `win_flush_seq`

## Requirements
- R1: After a request the output carries exactly this byte order: command 0x2A, four parameters, command 0x2B, four parameters, command 0x2C, then the pixel bytes.
- R2: Each window command's four parameters are first-coordinate high byte, first-coordinate low byte, last-coordinate high byte, last-coordinate low byte. The last coordinate is inclusive and is the requested end value.
- R3: The parameter LEFT_OFS is added to both column coordinates before they are sent. The parameter TOP_OFS is added to both row coordinates.
- R4: The pixel section holds (x1-x0+1)*(y1-y0+1) pixels of two bytes each.
- R5: In native mode (fmt32_i=0) each pixel is pix_data_i[15:0]. Without swap its high byte goes out first.
- R6: In XRGB mode (fmt32_i=1) a pixel is {pix_data_i[23:19], pix_data_i[15:10], pix_data_i[7:3]}. Bits 31:24 are discarded.
- R7: With swap_i=1 latched at the request, the low byte of every pixel goes out before the high byte.
- R8: out_dc_o is 0 for the three command bytes and 1 for every parameter and pixel byte.
- R9: A blank request sets the window to columns LEFT_OFS..LEFT_OFS+PANEL_W-1 and rows TOP_OFS..TOP_OFS+PANEL_H-1. It then sends PANEL_W*PANEL_H zero pixels and never raises pix_ready_o. Blank wins over a start request in the same cycle.
- R10: busy_o rises in the cycle after an accepted request. It stays high until the last pixel byte is accepted and is low in the next cycle.
- R11: start_i and blank_i are ignored while busy_o is high, including the cycle in which the last byte is accepted.
- R12: While out_valid_o is high and out_ready_i is low, out_byte_o and out_dc_o hold their values.
- R13: After reset busy_o, out_valid_o and pix_ready_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Flush request for the given rectangle |
| blank_i | input | 1 | Full-panel zero-fill request |
| x0_i | input | COORD_W | First column |
| x1_i | input | COORD_W | Last column (inclusive) |
| y0_i | input | COORD_W | First row |
| y1_i | input | COORD_W | Last row (inclusive) |
| fmt32_i | input | 1 | 1: source pixels are XRGB8888, 0: RGB565 |
| swap_i | input | 1 | 1: low byte of each pixel first |
| pix_valid_i | input | 1 | Source pixel valid |
| pix_data_i | input | 32 | Source pixel |
| pix_ready_o | output | 1 | Block takes a source pixel |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Link takes the output byte |
| out_byte_o | output | 8 | Command, parameter or pixel byte |
| out_dc_o | output | 1 | 0 command, 1 data |
| busy_o | output | 1 | Flush in progress |

## Verification
A new request can arrive in the very cycle the last pixel byte is accepted. In that cycle the sequencer ends one flush and could, if built wrongly, start another. The bench watches the byte stream and raises start_i for exactly the edge where the final byte's handshake happens. The run passes only if busy_o is low in the next cycle, stays low, and not one more byte appears. A second overlap is a blank and a start in the same cycle; the bench judges it from the window parameters and from whether pix_ready_o ever rises.

// File: rtl/wfs_pkg.sv
package wfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_PIX
    } wfs_state_e;

    localparam logic [7:0] OP_COL_WIN = 8'h2A;
    localparam logic [7:0] OP_ROW_WIN = 8'h2B;
    localparam logic [7:0] OP_MEM_WR  = 8'h2C;
    localparam int         HDR_LAST   = 10;

    // Window corners as sent on the link (offsets already applied)
    typedef struct packed {
        logic [15:0] xs;
        logic [15:0] xe;
        logic [15:0] ys;
        logic [15:0] ye;
    } wfs_win_t;

    // Pixel bytes in link order: b0 leaves first
    typedef struct packed {
        logic [7:0] b0;
        logic [7:0] b1;
    } wfs_pair_t;

    function automatic logic [15:0] xrgb_to_565(input logic [23:0] rgb);
        return {rgb[23:19], rgb[15:10], rgb[7:3]};
    endfunction

endpackage

// File: rtl/wfs_hdr_mux.sv
module wfs_hdr_mux
    import wfs_pkg::*;
(
    input  wfs_win_t   win_i,
    input  logic [3:0] idx_i,
    output logic [7:0] byte_o,
    output logic       dc_o
);
    always_comb begin
        dc_o = 1'b1;
        unique case (idx_i)
            4'd0:    begin byte_o = OP_COL_WIN; dc_o = 1'b0; end
            4'd1:    byte_o = win_i.xs[15:8];
            4'd2:    byte_o = win_i.xs[7:0];
            4'd3:    byte_o = win_i.xe[15:8];
            4'd4:    byte_o = win_i.xe[7:0];
            4'd5:    begin byte_o = OP_ROW_WIN; dc_o = 1'b0; end
            4'd6:    byte_o = win_i.ys[15:8];
            4'd7:    byte_o = win_i.ys[7:0];
            4'd8:    byte_o = win_i.ye[15:8];
            4'd9:    byte_o = win_i.ye[7:0];
            default: begin byte_o = OP_MEM_WR; dc_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/wfs_pix_conv.sv
module wfs_pix_conv
    import wfs_pkg::*;
(
    input  logic [31:0] data_i,
    input  logic        fmt32_i,
    input  logic        swap_i,
    input  logic        zero_i,
    output wfs_pair_t   pair_o
);
    logic [15:0] px;
    logic        unused_xbyte;

    assign unused_xbyte = ^data_i[31:24];

    always_comb begin
        px = fmt32_i ? xrgb_to_565(data_i[23:0]) : data_i[15:0];
        if (zero_i) px = '0;
        pair_o.b0 = swap_i ? px[7:0]  : px[15:8];
        pair_o.b1 = swap_i ? px[15:8] : px[7:0];
    end
endmodule

// File: rtl/wfs_pix_cnt.sv
module wfs_pix_cnt #(
    parameter int W = 34
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         last_o
);
    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)          remain <= '0;
        else if (load_i)  remain <= load_val_i;
        else if (dec_i)   remain <= remain - W'(1);
    end

    assign last_o = (remain == W'(1));
endmodule

// File: rtl/win_flush_seq.sv
module win_flush_seq
    import wfs_pkg::*;
#(
    parameter int COORD_W  = 16,
    parameter int LEFT_OFS = 0,
    parameter int TOP_OFS  = 0,
    parameter int PANEL_W  = 240,
    parameter int PANEL_H  = 320
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               blank_i,
    input  logic [COORD_W-1:0] x0_i,
    input  logic [COORD_W-1:0] x1_i,
    input  logic [COORD_W-1:0] y0_i,
    input  logic [COORD_W-1:0] y1_i,
    input  logic               fmt32_i,
    input  logic               swap_i,
    input  logic               pix_valid_i,
    input  logic [31:0]        pix_data_i,
    output logic               pix_ready_o,
    output logic               out_valid_o,
    input  logic               out_ready_i,
    output logic [7:0]         out_byte_o,
    output logic               out_dc_o,
    output logic               busy_o
);
    localparam int SPAN_W = COORD_W + 1;
    localparam int CNT_W  = 2 * SPAN_W;

    wfs_state_e  state;
    logic [3:0]  hdr_idx;
    wfs_win_t    win_q, win_nx;
    logic        fmt32_q, swap_q, blank_q;
    logic        have_pix, byte_sel;
    wfs_pair_t   pix_q, pix_nx;
    logic [CNT_W-1:0]  npix_nx;
    logic [SPAN_W-1:0] span_x, span_y;
    logic [7:0]  hdr_byte;
    logic        hdr_dc;
    logic        accept, fire, load_pix, pair_done, cnt_last;

    // Request decode: blank takes precedence over a rectangle
    always_comb begin
        span_x = {1'b0, x1_i} - {1'b0, x0_i} + SPAN_W'(1);
        span_y = {1'b0, y1_i} - {1'b0, y0_i} + SPAN_W'(1);
        if (blank_i) begin
            win_nx.xs = 16'(LEFT_OFS);
            win_nx.xe = 16'(LEFT_OFS + PANEL_W - 1);
            win_nx.ys = 16'(TOP_OFS);
            win_nx.ye = 16'(TOP_OFS + PANEL_H - 1);
            npix_nx   = CNT_W'(PANEL_W * PANEL_H);
        end else begin
            win_nx.xs = 16'(x0_i) + 16'(LEFT_OFS);
            win_nx.xe = 16'(x1_i) + 16'(LEFT_OFS);
            win_nx.ys = 16'(y0_i) + 16'(TOP_OFS);
            win_nx.ye = 16'(y1_i) + 16'(TOP_OFS);
            npix_nx   = CNT_W'(span_x) * CNT_W'(span_y);
        end
    end

    wfs_hdr_mux u_hdr (
        .win_i  (win_q),
        .idx_i  (hdr_idx),
        .byte_o (hdr_byte),
        .dc_o   (hdr_dc)
    );

    wfs_pix_conv u_conv (
        .data_i  (pix_data_i),
        .fmt32_i (fmt32_q),
        .swap_i  (swap_q),
        .zero_i  (blank_q),
        .pair_o  (pix_nx)
    );

    always_comb begin
        accept      = (state == ST_IDLE) && (start_i || blank_i);
        out_valid_o = (state == ST_HDR) || ((state == ST_PIX) && have_pix);
        fire        = out_valid_o && out_ready_i;
        pix_ready_o = (state == ST_PIX) && !have_pix && !blank_q;
        load_pix    = (state == ST_PIX) && !have_pix && (blank_q || pix_valid_i);
        pair_done   = (state == ST_PIX) && have_pix && byte_sel && fire;
        busy_o      = (state != ST_IDLE);
        if (state == ST_HDR) begin
            out_byte_o = hdr_byte;
            out_dc_o   = hdr_dc;
        end else begin
            out_byte_o = byte_sel ? pix_q.b1 : pix_q.b0;
            out_dc_o   = 1'b1;
        end
    end

    wfs_pix_cnt #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept),
        .load_val_i (npix_nx),
        .dec_i      (pair_done),
        .last_o     (cnt_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            hdr_idx  <= '0;
            win_q    <= '0;
            fmt32_q  <= 1'b0;
            swap_q   <= 1'b0;
            blank_q  <= 1'b0;
            have_pix <= 1'b0;
            byte_sel <= 1'b0;
            pix_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_HDR;
                        hdr_idx  <= '0;
                        win_q    <= win_nx;
                        fmt32_q  <= fmt32_i;
                        swap_q   <= swap_i;
                        blank_q  <= blank_i;
                        have_pix <= 1'b0;
                        byte_sel <= 1'b0;
                    end
                end
                ST_HDR: begin
                    if (fire) begin
                        if (hdr_idx == 4'(HDR_LAST)) state <= ST_PIX;
                        else hdr_idx <= hdr_idx + 4'd1;
                    end
                end
                ST_PIX: begin
                    if (load_pix) begin
                        pix_q    <= pix_nx;
                        have_pix <= 1'b1;
                    end else if (fire) begin
                        if (!byte_sel) begin
                            byte_sel <= 1'b1;
                        end else begin
                            byte_sel <= 1'b0;
                            have_pix <= 1'b0;
                            if (cnt_last) state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/win_flush_seq_chk.sv
module win_flush_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       blank_i,
    input logic       pix_ready_o,
    input logic       out_valid_o,
    input logic       out_ready_i,
    input logic [7:0] out_byte_o,
    input logic       out_dc_o,
    input logic       busy_o
);
    // R12: byte and flag frozen under backpressure
    a_r12_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_byte_o) && $stable(out_dc_o)));

    // R8: a byte flagged as command is one of the three window opcodes
    a_r8_cmd_code: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_dc_o) |-> (out_byte_o == 8'h2A || out_byte_o == 8'h2B || out_byte_o == 8'h2C));

    // R10: an idle request makes the block busy next cycle
    a_r10_busy_rise: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (start_i || blank_i)) |=> busy_o);

    // R10: nothing is offered or pulled while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!out_valid_o && !pix_ready_o));

    // R1: a busy period always opens with the column-window command
    a_r1_first_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (out_valid_o && !out_dc_o && out_byte_o == 8'h2A));

    // R13: reset leaves the block idle
    a_r13_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy_o && !out_valid_o && !pix_ready_o));
endmodule

bind win_flush_seq win_flush_seq_chk u_chk (.*);

// File: tb/tb_win_flush_seq.sv
module tb_win_flush_seq;
    localparam int CW = 16;
    localparam int LO = 2;
    localparam int TO = 3;
    localparam int PW = 4;
    localparam int PH = 3;

    typedef struct packed {
        logic [15:0] x0;
        logic [15:0] x1;
        logic [15:0] y0;
        logic [15:0] y1;
        logic        fmt;
        logic        swp;
        logic        stl;
        logic [15:0] nb;
    } vec_t;

    localparam vec_t VECS [0:4] = '{
        '{16'd0,   16'd0,   16'd0,   16'd0,   1'b0, 1'b0, 1'b0, 16'd13},
        '{16'd1,   16'd2,   16'd0,   16'd1,   1'b0, 1'b1, 1'b1, 16'd19},
        '{16'd3,   16'd5,   16'd2,   16'd2,   1'b1, 1'b0, 1'b0, 16'd17},
        '{16'd0,   16'd1,   16'd0,   16'd1,   1'b1, 1'b1, 1'b1, 16'd19},
        '{16'd300, 16'd301, 16'd256, 16'd256, 1'b0, 1'b0, 1'b1, 16'd15}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_q = 1'b0, blank_i = 1'b0, late_start = 1'b0;
    logic start_i;
    logic [CW-1:0] x0_i = '0, x1_i = '0, y0_i = '0, y1_i = '0;
    logic fmt32_i = 1'b0, swap_i = 1'b0;
    logic pix_valid_i = 1'b0;
    logic [31:0] pix_data_i = '0;
    logic pix_ready_o, out_valid_o, out_dc_o, busy_o;
    logic out_ready_i = 1'b0;
    logic [7:0] out_byte_o;

    assign start_i = start_q | late_start;

    always #10 clk = ~clk;

    win_flush_seq #(.COORD_W(CW), .LEFT_OFS(LO), .TOP_OFS(TO), .PANEL_W(PW), .PANEL_H(PH)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .blank_i(blank_i),
        .x0_i(x0_i), .x1_i(x1_i), .y0_i(y0_i), .y1_i(y1_i),
        .fmt32_i(fmt32_i), .swap_i(swap_i),
        .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i), .pix_ready_o(pix_ready_o),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .out_byte_o(out_byte_o), .out_dc_o(out_dc_o), .busy_o(busy_o)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    logic [7:0] rec_b [0:255];
    logic       rec_dc [0:255];
    int         rec_n = 0;
    logic [7:0] exp_b [0:255];
    logic       exp_dc [0:255];
    int         exp_n = 0;
    logic stall = 1'b0, feed_en = 1'b0, feed_take = 1'b0, late_arm = 1'b0, ready_seen = 1'b0;
    int   feed_idx = 0;

    function automatic logic [31:0] src_pix(input int k);
        logic [7:0] kb;
        kb = 8'(k);
        return {8'hC3 ^ kb, 8'(k * 29 + 1), 8'(k * 53 + 7), 8'(k * 11 + 200)};
    endfunction

    task automatic chk(input logic ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    // Link sink, pixel source and recorder, all moved at the falling edge
    always @(negedge clk) begin
        cyc++;
        late_start = 1'b0;
        out_ready_i = !stall || ((cyc % 3) != 0);
        if (out_valid_o && out_ready_i) begin
            if (rec_n < 256) begin
                rec_b[rec_n]  = out_byte_o;
                rec_dc[rec_n] = out_dc_o;
            end
            rec_n++;
            if (late_arm && rec_n == exp_n) late_start = 1'b1;
        end
        if (feed_take) feed_idx++;
        pix_valid_i = feed_en && (!stall || ((cyc % 4) != 1));
        pix_data_i  = src_pix(feed_idx);
        feed_take   = pix_valid_i && pix_ready_o;
        if (pix_ready_o) ready_seen = 1'b1;
        if (cyc >= 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic push(input logic [7:0] b, input logic dc);
        exp_b[exp_n]  = b;
        exp_dc[exp_n] = dc;
        exp_n++;
    endtask

    task automatic build_exp(input logic [15:0] x0, x1, y0, y1, input logic fmt, swp, blk);
        logic [15:0] xs, xe, ys, ye, p;
        logic [31:0] d;
        int np;
        if (blk) begin
            xs = 16'(LO); xe = 16'(LO + PW - 1); ys = 16'(TO); ye = 16'(TO + PH - 1);
            np = PW * PH;
        end else begin
            xs = x0 + 16'(LO); xe = x1 + 16'(LO); ys = y0 + 16'(TO); ye = y1 + 16'(TO);
            np = (int'(x1) - int'(x0) + 1) * (int'(y1) - int'(y0) + 1);
        end
        exp_n = 0;
        push(8'h2A, 1'b0); push(xs[15:8], 1'b1); push(xs[7:0], 1'b1); push(xe[15:8], 1'b1); push(xe[7:0], 1'b1);
        push(8'h2B, 1'b0); push(ys[15:8], 1'b1); push(ys[7:0], 1'b1); push(ye[15:8], 1'b1); push(ye[7:0], 1'b1);
        push(8'h2C, 1'b0);
        for (int k = 0; k < np; k++) begin
            d = src_pix(k);
            if (blk)      p = 16'h0000;
            else if (fmt) p = {d[23:19], d[15:10], d[7:3]};
            else          p = d[15:0];
            if (swp) begin push(p[7:0], 1'b1); push(p[15:8], 1'b1); end
            else     begin push(p[15:8], 1'b1); push(p[7:0], 1'b1); end
        end
    endtask

    task automatic cmp_bytes(input int lo, input int hi, input string req);
        int bi;
        bi = -1;
        for (int i = lo; i < hi; i++)
            if (bi < 0 && i < 256 && rec_b[i] !== exp_b[i]) bi = i;
        n_chk++;
        if (bi >= 0) begin
            n_bad++;
            $display("FAIL %s byte %0d actual=%02h expected=%02h", req, bi, rec_b[bi], exp_b[bi]);
        end
    endtask

    task automatic cmp_dc(input string req);
        int bi;
        bi = -1;
        for (int i = 0; i < exp_n; i++)
            if (bi < 0 && rec_dc[i] !== exp_dc[i]) bi = i;
        n_chk++;
        if (bi >= 0) begin
            n_bad++;
            $display("FAIL %s dc at byte %0d actual=%0b expected=%0b", req, bi, rec_dc[bi], exp_dc[bi]);
        end
    endtask

    task automatic wait_idle();
        int g;
        g = 0;
        while (busy_o && g < 3000) begin
            @(negedge clk);
            g++;
        end
    endtask

    // One flush; mid_poke issues extra requests while busy
    task automatic run_flush(input vec_t v, input logic blk, input logic mid_poke, input string tag);
        @(negedge clk);
        x0_i = v.x0; x1_i = v.x1; y0_i = v.y0; y1_i = v.y1;
        fmt32_i = v.fmt; swap_i = v.swp; stall = v.stl;
        feed_idx = 0; rec_n = 0; ready_seen = 1'b0;
        build_exp(v.x0, v.x1, v.y0, v.y1, v.fmt, v.swp, blk);
        feed_en = !blk;
        start_q = 1'b1;
        blank_i = blk;
        @(negedge clk);
        start_q = 1'b0;
        blank_i = 1'b0;
        chk(busy_o === 1'b1, $sformatf("R10 %s busy after request actual=%0b expected=1", tag, busy_o));
        if (mid_poke) begin
            repeat (5) @(negedge clk);
            x0_i = 16'd7; x1_i = 16'd9; fmt32_i = ~v.fmt; swap_i = ~v.swp;
            start_q = 1'b1; blank_i = 1'b1;
            @(negedge clk);
            start_q = 1'b0; blank_i = 1'b0;
        end
        wait_idle();
        feed_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13: state right after reset
        chk(busy_o === 1'b0, $sformatf("R13 busy actual=%0b expected=0", busy_o));
        chk(out_valid_o === 1'b0, $sformatf("R13 out_valid actual=%0b expected=0", out_valid_o));
        chk(pix_ready_o === 1'b0, $sformatf("R13 pix_ready actual=%0b expected=0", pix_ready_o));
        rst = 1'b0;
        @(negedge clk);

        // Table walk: R1..R8 and R10 under native, XRGB, swap and throttled traffic
        for (int vi = 0; vi < 5; vi++) begin
            run_flush(VECS[vi], 1'b0, 1'b0, $sformatf("vec%0d", vi));
            chk(rec_n == int'(VECS[vi].nb),
                $sformatf("R4 vec%0d byte count actual=%0d expected=%0d", vi, rec_n, VECS[vi].nb));
            cmp_bytes(0, 11, $sformatf("R1 R2 R3 vec%0d header", vi));
            cmp_bytes(11, exp_n, VECS[vi].fmt ? $sformatf("R6 R7 vec%0d pixels", vi)
                                              : $sformatf("R5 R7 vec%0d pixels", vi));
            cmp_dc($sformatf("R8 vec%0d", vi));
            chk(busy_o === 1'b0, $sformatf("R10 vec%0d busy after last byte actual=%0b expected=0", vi, busy_o));
        end

        // R9: blank together with start; blank wins and the source stays untouched
        run_flush('{16'd1, 16'd1, 16'd1, 16'd1, 1'b1, 1'b0, 1'b1, 16'd0}, 1'b1, 1'b0, "blank");
        chk(rec_n == 11 + 2 * PW * PH,
            $sformatf("R9 blank byte count actual=%0d expected=%0d", rec_n, 11 + 2 * PW * PH));
        cmp_bytes(0, 11, "R9 R3 blank window");
        cmp_bytes(11, exp_n, "R9 blank zero pixels");
        chk(ready_seen === 1'b0, $sformatf("R9 pix_ready seen actual=%0b expected=0", ready_seen));

        // R11: requests while busy are ignored
        run_flush(VECS[1], 1'b0, 1'b1, "poke");
        chk(rec_n == int'(VECS[1].nb),
            $sformatf("R11 poke byte count actual=%0d expected=%0d", rec_n, VECS[1].nb));
        cmp_bytes(0, exp_n, "R11 poke stream");
        repeat (10) @(negedge clk);
        chk(busy_o === 1'b0 && rec_n == int'(VECS[1].nb),
            $sformatf("R11 poke restart busy=%0b bytes=%0d expected busy=0 bytes=%0d", busy_o, rec_n, VECS[1].nb));

        // R10/R11 corner: start raised in the cycle the last byte is accepted
        late_arm = 1'b1;
        run_flush(VECS[2], 1'b0, 1'b0, "late");
        chk(busy_o === 1'b0, $sformatf("R10 late busy after last byte actual=%0b expected=0", busy_o));
        late_arm = 1'b0;
        repeat (12) @(negedge clk);
        chk(busy_o === 1'b0 && rec_n == int'(VECS[2].nb),
            $sformatf("R11 late start busy=%0b bytes=%0d expected busy=0 bytes=%0d", busy_o, rec_n, VECS[2].nb));
        cmp_bytes(0, exp_n, "R11 late stream");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule